// File: doc/BRIEF.md
# Open-Drain Two-Wire Bus Master Byte Engine

This block is a bit-level master for a two-wire serial bus in which both lines are open drain. A controller hands it one byte-sized command at a time. A write command sends eight data bits and then clocks in the slave's acknowledge. It can optionally begin with a START condition and end with a STOP condition. A read command clocks eight bits in from the slave and then ends the byte in one of two ways: the master drives an acknowledge, or it gives one more clock with the data line released and then issues a STOP.

The engine never drives a line high. Each line has one output, a pull-low enable, and the engine reads the actual pin levels back through a two-stage synchronizer. After it releases the clock line, it polls the clock pin in fixed two-microsecond steps, so a slave may stretch the clock. If the pin stays low for longer than a set limit, the engine flags a timeout and carries on. Every STOP is followed by a mandatory idle interval before the engine accepts another command.

All time intervals are counted in clock ticks through a ticks-per-microsecond parameter. The bus timing therefore scales with the system clock.

Top module: `twi_byte_master`

## Requirements
- R1: During and after reset both pull-low enables (`scl_oe`, `sda_oe`) are 0, `cmd_ready` is 1 and `done` is 0.
- R2: The data-line enable changes while the clock-line enable is released only inside a START or STOP sequence. Every other data change happens with the clock held low.
- R3: A write shifts `cmd_wdata` out most significant bit first. Each bit is valid on the bus at the rising clock edge that carries it.
- R4: With `cmd_start`=1, a write first raises SDA, then releases SCL, then pulls SDA low while SCL is high (a START), then pulls SCL low. With `cmd_start`=0, no START appears.
- R5: After the eighth bit of a write, SDA is released and a ninth clock is given. `ack_ok` is 1 exactly when SDA was low during that clock. If no STOP was requested, SCL is left pulled low.
- R6: With `cmd_stop`=1, the byte ends with SDA rising while SCL is high (a STOP). `done` is not raised until at least `BUS_FREE_US` microseconds of ticks after that STOP.
- R7: A read (`cmd_read`=1) samples SDA during eight clock-high phases, MSB first, and returns the byte on `rdata` with `done`. A read never issues a START, and `ack_ok` is 0 for reads.
- R8: A read with `cmd_stop`=0 pulls SDA low for a ninth clock (an acknowledge) and then releases SDA.
- R9: A read with `cmd_stop`=1 gives a ninth clock with SDA released and then a STOP.
- R10: After releasing SCL, the engine waits until the pin reads high before continuing. A stretch shorter than `STRETCH_US` still yields correct data and `stretch_timeout`=0.
- R11: If SCL stays low for about `STRETCH_US` after a release, the engine continues anyway, and `done` reports `stretch_timeout`=1 for that command.
- R12: A command is taken when `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` then stays 0 until the command completes. `done` is a one-cycle pulse, and `rdata`, `ack_ok` and `stretch_timeout` hold their values while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, able to take a command |
| cmd_read | input | 1 | 1 = read a byte, 0 = write a byte |
| cmd_start | input | 1 | Write only: precede the byte with START |
| cmd_stop | input | 1 | End the byte with STOP (for a read, also means last byte) |
| cmd_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte read from the slave |
| ack_ok | output | 1 | Slave acknowledged the written byte |
| stretch_timeout | output | 1 | Clock was held low past the limit during this command |
| scl_i | input | 1 | Clock pin level |
| sda_i | input | 1 | Data pin level |
| scl_oe | output | 1 | Pull clock line low |
| sda_oe | output | 1 | Pull data line low |

## Verification
Some rules are checked by the assertions on every cycle:
- SDA moves with SCL released only inside START or STOP.
- `done` lasts a single cycle, and `cmd_ready` drops after acceptance.
- Any completion that follows a STOP comes straight out of the bus-free wait.
- The timeout flag rises only from a clock poll that saw the pin low.
- The clock line is left pulled low after a byte that ends without a STOP.

Other behaviour can only be shown by the scenarios, where a slave model drives acknowledges, read data and clock stretching. These cover the bit order on the wire, the presence or absence of START and STOP, the acknowledge level on the ninth clock of each read style, the length of the bus-free gap, and the returned data and flags.

// File: rtl/twi_byte_master.sv
module twi_byte_master #(
  parameter int TICKS_PER_US = 100,
  parameter int STRETCH_US   = 1000,
  parameter int BUS_FREE_US  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic       cmd_read,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic [7:0] cmd_wdata,
  output logic       done,
  output logic [7:0] rdata,
  output logic       ack_ok,
  output logic       stretch_timeout,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);

  localparam int STEP_T = 2 * TICKS_PER_US;
  localparam int FREE_T = BUS_FREE_US * TICKS_PER_US;
  localparam int TW     = $clog2(FREE_T + STEP_T + 1);
  localparam int POLLS  = (STRETCH_US / 2 > 0) ? STRETCH_US / 2 : 1;
  localparam int SW     = $clog2(POLLS + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_XFER, ST_ACK, ST_STOP} st_t;
  typedef enum logic [2:0] {A_SDA_HI, A_SDA_LO, A_SCL_LO, A_SCL_HI, A_PAUSE, A_SAMPLE, A_FREE} act_t;

  st_t          st;
  act_t         act;
  logic [2:0]   sub, last_sub, bitn;
  logic         go, is_rd, do_stop;
  logic [TW-1:0] tmr, dly;
  logic [SW-1:0] scnt;
  logic [7:0]   shreg;
  logic         scl_m, scl_s, sda_m, sda_s;
  logic         to_flag, ack_r;

  assign cmd_ready       = (st == ST_IDLE);
  assign rdata           = shreg;
  assign ack_ok          = ack_r;
  assign stretch_timeout = to_flag;

  always_comb begin
    act      = A_SCL_LO;
    last_sub = 3'd0;
    case (st)
      ST_START: begin
        last_sub = 3'd4;
        case (sub)
          3'd0: act = A_SDA_HI;
          3'd1: act = A_SCL_HI;
          3'd2: act = A_SDA_LO;
          3'd3: act = A_PAUSE;
          default: act = A_SCL_LO;
        endcase
      end
      ST_XFER: begin
        if (!is_rd) begin
          last_sub = 3'd2;
          case (sub)
            3'd0: act = shreg[7] ? A_SDA_HI : A_SDA_LO;
            3'd1: act = A_SCL_HI;
            default: act = A_SCL_LO;
          endcase
        end else begin
          last_sub = 3'd3;
          case (sub)
            3'd0: act = A_SDA_HI;
            3'd1: act = A_SCL_HI;
            3'd2: act = A_SAMPLE;
            default: act = A_SCL_LO;
          endcase
        end
      end
      ST_ACK: begin
        if (!is_rd) begin
          last_sub = 3'd3;
          case (sub)
            3'd0: act = A_SDA_HI;
            3'd1: act = A_SCL_HI;
            3'd2: act = A_SAMPLE;
            default: act = A_SCL_LO;
          endcase
        end else if (do_stop) begin
          act = A_SCL_HI;
        end else begin
          last_sub = 3'd3;
          case (sub)
            3'd0: act = A_SDA_LO;
            3'd1: act = A_SCL_HI;
            3'd2: act = A_SCL_LO;
            default: act = A_SDA_HI;
          endcase
        end
      end
      ST_STOP: begin
        last_sub = 3'd4;
        case (sub)
          3'd0: act = A_SCL_LO;
          3'd1: act = A_SDA_LO;
          3'd2: act = A_SCL_HI;
          3'd3: act = A_SDA_HI;
          default: act = A_FREE;
        endcase
      end
      default: act = A_SCL_LO;
    endcase
  end

  always_comb begin
    case (act)
      A_PAUSE:  dly = TW'(TICKS_PER_US - 1);
      A_SAMPLE: dly = '0;
      A_FREE:   dly = TW'(FREE_T - 1);
      default:  dly = TW'(STEP_T - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m;
      sda_m <= sda_i; sda_s <= sda_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; sub <= '0; bitn <= '0; go <= 1'b0;
      tmr <= '0; scnt <= '0; is_rd <= 1'b0; do_stop <= 1'b0;
      shreg <= '0; to_flag <= 1'b0; ack_r <= 1'b0; done <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        if (cmd_valid) begin
          is_rd   <= cmd_read;
          do_stop <= cmd_stop;
          shreg   <= cmd_read ? 8'h00 : cmd_wdata;
          to_flag <= 1'b0;
          ack_r   <= 1'b0;
          sub     <= '0;
          bitn    <= 3'd7;
          go      <= 1'b0;
          st      <= (cmd_start && !cmd_read) ? ST_START : ST_XFER;
        end
      end else if (!go) begin
        go   <= 1'b1;
        scnt <= '0;
        tmr  <= dly;
        case (act)
          A_SDA_HI: sda_oe <= 1'b0;
          A_SDA_LO: sda_oe <= 1'b1;
          A_SCL_LO: scl_oe <= 1'b1;
          A_SCL_HI: scl_oe <= 1'b0;
          A_SAMPLE: if (st == ST_ACK) ack_r <= !sda_s;
                    else shreg <= {shreg[6:0], sda_s};
          default: ;
        endcase
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end else if (act == A_SCL_HI && !scl_s && scnt != SW'(POLLS - 1)) begin
        scnt <= scnt + 1'b1;
        tmr  <= TW'(STEP_T - 1);
      end else begin
        if (act == A_SCL_HI && !scl_s) to_flag <= 1'b1;
        go <= 1'b0;
        if (sub != last_sub) begin
          sub <= sub + 1'b1;
        end else begin
          sub <= '0;
          case (st)
            ST_START: st <= ST_XFER;
            ST_XFER: begin
              if (!is_rd) shreg <= {shreg[6:0], 1'b0};
              if (bitn == 3'd0) st <= ST_ACK;
              else bitn <= bitn - 1'b1;
            end
            ST_ACK: begin
              if (do_stop) st <= ST_STOP;
              else begin st <= ST_IDLE; done <= 1'b1; end
            end
            default: begin st <= ST_IDLE; done <= 1'b1; end
          endcase
        end
      end
    end
  end

  a_r2_sda_moves_under_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe) && !$past(scl_oe)) |-> (st == ST_START || st == ST_STOP));

  a_r12_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_ready_drops_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  a_r6_free_wait_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && do_stop) |-> $past(act == A_FREE));

  a_r11_timeout_from_low_poll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_flag) |-> $past(act == A_SCL_HI && !scl_s));

  a_r5_clock_left_low: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !do_stop) |-> scl_oe);

endmodule

// File: tb/tb_twi_byte_master.sv
module tb_twi_byte_master;
  localparam int TPU  = 2;
  localparam int STR  = 40;
  localparam int FREE = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_read = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0;
  logic [7:0] cmd_wdata = 8'h00;
  logic cmd_ready, done, ack_ok, stretch_timeout, scl_oe, sda_oe;
  logic [7:0] rdata;
  logic scl_line, sda_line, slv_sda_low, slv_scl_hold;

  always #4 clk = ~clk;

  assign scl_line = !scl_oe && !slv_scl_hold;
  assign sda_line = !sda_oe && !slv_sda_low;

  twi_byte_master #(.TICKS_PER_US(TPU), .STRETCH_US(STR), .BUS_FREE_US(FREE)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_read(cmd_read), .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_wdata(cmd_wdata),
    .done(done), .rdata(rdata), .ack_ok(ack_ok), .stretch_timeout(stretch_timeout),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe));

  typedef struct packed {
    logic       rd, st, sp, full;
    logic [7:0] wd, e_rd;
    logic       e_ack, e_to;
  } item_t;
  item_t exp_q[$];

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, stop_cyc = 0;
  logic m_rd = 1'b0, m_ack = 1'b0;
  logic [7:0] m_byte = 8'h00;
  int stretch_len = 0, hold_cnt = 0;
  int rise = 0, starts = 0, stops = 0;
  logic [9:0] bitv = '0;
  logic scl_q = 1'b1, sda_q = 1'b1, rdy_q = 1'b1, scl_oe_q = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  assign slv_scl_hold = (hold_cnt > 0) || (stretch_len > 0 && scl_oe_q && !scl_oe);

  always_comb begin
    int idx;
    slv_sda_low = 1'b0;
    idx = scl_q ? rise - 1 : rise;
    if (!m_rd && m_ack && ((rise == 8 && !scl_q) || (rise == 9 && scl_q))) slv_sda_low = 1'b1;
    if (m_rd && idx >= 0 && idx < 8 && !m_byte[7 - idx]) slv_sda_low = 1'b1;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    scl_oe_q <= scl_oe;
    if (scl_oe_q && !scl_oe && stretch_len > 0) hold_cnt <= stretch_len;
    else if (hold_cnt > 0) hold_cnt <= hold_cnt - 1;
    scl_q <= scl_line;
    sda_q <= sda_line;
    rdy_q <= cmd_ready;
    if (rdy_q && !cmd_ready) begin
      rise <= 0; starts <= 0; stops <= 0; bitv <= '0;
    end else begin
      if (scl_line && !scl_q) begin
        if (rise + 1 <= 9) bitv[rise + 1] <= sda_line;
        rise <= rise + 1;
      end
      if (scl_q && scl_line && sda_q && !sda_line) begin starts <= starts + 1; rise <= 0; end
      if (scl_q && scl_line && !sda_q && sda_line) begin stops <= stops + 1; stop_cyc <= cyc; end
    end
    if (done) begin
      item_t e;
      if (exp_q.size() == 0) chk(1'b0, "R12 unexpected done", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk(stretch_timeout == e.e_to, e.e_to ? "R11 timeout flag" : "R10 timeout flag", stretch_timeout, e.e_to);
        if (e.full) begin
          chk(ack_ok == e.e_ack, e.rd ? "R7 ack_ok on read" : "R5 ack_ok", ack_ok, e.e_ack);
          chk(starts == int'(e.st), "R4 start count", starts, e.st);
          chk(stops == int'(e.sp), "R6 stop count", stops, e.sp);
          if (e.sp) chk(cyc - stop_cyc >= FREE * TPU, "R6 bus-free gap", cyc - stop_cyc, FREE * TPU);
          if (!e.rd) chk({bitv[1], bitv[2], bitv[3], bitv[4], bitv[5], bitv[6], bitv[7], bitv[8]} == e.wd,
                         "R3 bits on wire", {bitv[1], bitv[2], bitv[3], bitv[4], bitv[5], bitv[6], bitv[7], bitv[8]}, e.wd);
          else begin
            chk(rdata == e.e_rd, "R7 rdata", rdata, e.e_rd);
            if (e.sp) chk(bitv[9] == 1'b1, "R9 ninth clock released", bitv[9], 1);
            else      chk(bitv[9] == 1'b0, "R8 master ack low", bitv[9], 0);
          end
        end
      end
    end
  end

  task automatic issue(input bit rd, input bit st, input bit sp, input logic [7:0] wd,
                       input logic [7:0] sbyte, input bit sack, input int hold,
                       input bit e_ack, input bit e_to, input bit full);
    item_t e;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    m_rd = rd; m_ack = sack; m_byte = sbyte; stretch_len = hold;
    e.rd = rd; e.st = st; e.sp = sp; e.full = full; e.wd = wd; e.e_rd = sbyte;
    e.e_ack = e_ack; e.e_to = e_to;
    exp_q.push_back(e);
    cmd_valid = 1'b1; cmd_read = rd; cmd_start = st; cmd_stop = sp; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R12 ready low while busy", cmd_ready, 0);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic reset_checks;
    chk(!scl_oe, "R1 scl_oe", scl_oe, 0);
    chk(!sda_oe, "R1 sda_oe", sda_oe, 0);
    chk(cmd_ready, "R1 cmd_ready", cmd_ready, 1);
    chk(!done, "R1 done", done, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    reset_checks();
    rst_n = 1'b1;
    issue(1'b0, 1'b1, 1'b0, 8'hA6, 8'h00, 1'b1, 0, 1'b1, 1'b0, 1'b1);
    issue(1'b0, 1'b0, 1'b0, 8'h3C, 8'h00, 1'b1, 0, 1'b1, 1'b0, 1'b1);
    issue(1'b0, 1'b0, 1'b1, 8'h5A, 8'h00, 1'b0, 0, 1'b0, 1'b0, 1'b1);
    issue(1'b0, 1'b1, 1'b0, 8'hA1, 8'h00, 1'b1, 0, 1'b1, 1'b0, 1'b1);
    issue(1'b1, 1'b0, 1'b0, 8'h00, 8'hC3, 1'b0, 0, 1'b0, 1'b0, 1'b1);
    issue(1'b1, 1'b0, 1'b1, 8'h00, 8'h5E, 1'b0, 0, 1'b0, 1'b0, 1'b1);
    issue(1'b0, 1'b1, 1'b1, 8'h81, 8'h00, 1'b1, 10 * TPU, 1'b1, 1'b0, 1'b1);
    issue(1'b0, 1'b1, 1'b0, 8'h47, 8'h00, 1'b1, 100 * TPU, 1'b0, 1'b1, 1'b0);
    stretch_len = 0;
    rst_n = 1'b0;
    repeat (300) @(negedge clk);
    reset_checks();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R12 watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule